// File: doc/BRIEF.md
# Region-to-LED Serial Streamer

This block turns a small set of per-region colors into the pixel stream for a chain of individually addressable LEDs driven over one data wire. Each region has an 8-bit repeat count, and the block sends that region's color to that many consecutive LEDs. The block never holds a color per LED: a strip of any length is driven from one color and one count per region. For example, five regions with counts 2,2,1,2,2 light nine LEDs.

A frame-update pulse starts one refresh. At that moment the block copies in the colors, the counts and the mode. The mode picks between live averaged colors and custom colors. It then walks the regions in index order, skips any region whose count is zero, and sends each color as 24 pulse-width-coded bits. After the last LED it keeps the wire low for a latch period so that the whole chain shows the new data. Only after that does it accept the next frame-update pulse.

Top module: `ledStreamer`

## Requirements
- R1: A `frameStart` pulse seen while idle starts a refresh, and `busy` is high from the following cycle until the latch period ends.
- R2: Regions are sent in ascending index order, starting at region 0. Region k's color goes to exactly `regionCounts[8k+7:8k]` consecutive LEDs, so a refresh carries 24 times the sum of the counts in bits.
- R3: A region with count zero sends no bits, and the next region follows it directly.
- R4: A region's color is packed in the color inputs as red in bits 23:16, green in 15:8 and blue in 7:0 of its 24-bit slot (slot k is bits 24k+23:24k). On the wire each LED's bytes go out in the order green, red, blue, with the most significant bit first.
- R5: Each bit starts with a high pulse of exactly T0H cycles for a 0 or exactly T1H cycles for a 1. The line is then low for the rest of a TBIT-cycle bit slot.
- R6: `modeCustom`=1 selects `customColors` for the refresh, and 0 selects `liveColors`.
- R7: Colors, counts and mode are sampled when the refresh starts. Changing them during the refresh does not change the bits sent in that refresh.
- R8: After the last bit of the last LED, `ledData` stays low for at least LATCH_CYC cycles before `busy` falls. A `frameStart` pulse while `busy` is high is ignored and does not start a second refresh.
- R9: While reset is asserted and just after it, `ledData` and `busy` are low.
- R10: `ledData` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Single-cycle request to start a refresh |
| modeCustom | input | 1 | 1 = custom colors, 0 = live averaged colors |
| liveColors | input | NUM_REGIONS*24 | Averaged region colors, RGB per 24-bit slot |
| customColors | input | NUM_REGIONS*24 | Programmed region colors, RGB per 24-bit slot |
| regionCounts | input | NUM_REGIONS*CNT_W | LED repeat count per region |
| ledData | output | 1 | Serial data line to the LED chain |
| busy | output | 1 | High while a refresh and its latch period are in progress |

## Verification
The checker watches properties that hold on every cycle: the line stays quiet while idle, every high pulse is exactly T0H or T1H long, the line has been low for at least the latch period whenever `busy` drops, and a refresh begins only after a frame-update pulse. Other properties depend on a whole refresh and only the bench can show them. These are the order of regions and bytes, the exact number of repeats per region, the skipping of zero-count regions, the choice of color source by mode, and the freezing of inputs during a refresh. For these the bench decodes the pulse widths back into bits and compares the full stream against one built from the counts and colors it applied.

// File: rtl/ledStreamPkg.sv
package ledStreamPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_LATCH = 2'd3
  } walkState_t;

  // strobes from the walker to the bit datapath
  typedef struct packed {
    logic capture;     // copy selected color set into the hold register
    logic startPixel;  // load one region color and begin its 24 bits
  } ctrlStrobes_t;

  localparam int unsigned PIXEL_BITS = 24;

endpackage

// File: rtl/ledCtrl.sv
module ledCtrl
  import ledStreamPkg::*;
#(
  parameter int unsigned NUM_REGIONS = 5,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned LATCH_CYC   = 40,
  localparam int unsigned IDX_W      = $clog2(NUM_REGIONS + 1),
  localparam int unsigned LATCH_W    = $clog2(LATCH_CYC + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         frameStart,
  input  logic [NUM_REGIONS*CNT_W-1:0] regionCounts,
  input  logic                         pixelDone,
  output ctrlStrobes_t                 strobes,
  output logic [IDX_W-1:0]             regionSel,
  output logic                         busy
);

  localparam logic [IDX_W-1:0]   LAST_IDX  = IDX_W'(NUM_REGIONS);
  localparam logic [LATCH_W-1:0] LATCH_END = LATCH_W'(LATCH_CYC - 1);

  walkState_t                         state;
  logic [NUM_REGIONS-1:0][CNT_W-1:0]  heldCounts;
  logic [CNT_W-1:0]                   sentCnt;
  logic [LATCH_W-1:0]                 latchCnt;
  logic                               regionLeft;
  logic                               moreToSend;

  assign regionLeft = (regionSel < LAST_IDX);
  assign moreToSend = regionLeft && (sentCnt != heldCounts[regionSel]);

  always_comb begin
    strobes            = '0;
    strobes.capture    = (state == ST_IDLE) && frameStart;
    strobes.startPixel = (state == ST_SCAN) && moreToSend;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      heldCounts <= '0;
      regionSel  <= '0;
      sentCnt    <= '0;
      latchCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (frameStart) begin
            heldCounts <= regionCounts;
            regionSel  <= '0;
            sentCnt    <= '0;
            state      <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (!regionLeft) begin
            latchCnt <= '0;
            state    <= ST_LATCH;
          end else if (moreToSend) begin
            sentCnt <= sentCnt + 1'b1;
            state   <= ST_WAIT;
          end else begin
            regionSel <= regionSel + 1'b1;
            sentCnt   <= '0;
          end
        end
        ST_WAIT: begin
          if (pixelDone) state <= ST_SCAN;
        end
        ST_LATCH: begin
          if (latchCnt == LATCH_END) state <= ST_IDLE;
          else latchCnt <= latchCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ledDatapath.sv
module ledDatapath
  import ledStreamPkg::*;
#(
  parameter int unsigned NUM_REGIONS = 5,
  parameter int unsigned T0H         = 2,
  parameter int unsigned T1H         = 5,
  parameter int unsigned TBIT        = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_REGIONS + 1),
  localparam int unsigned TICK_W     = $clog2(TBIT + 1),
  localparam int unsigned BIT_W      = $clog2(PIXEL_BITS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic [IDX_W-1:0]          regionSel,
  input  logic                      modeCustom,
  input  logic [NUM_REGIONS*24-1:0] liveColors,
  input  logic [NUM_REGIONS*24-1:0] customColors,
  output logic                      pixelDone,
  output logic                      ledData
);

  localparam logic [TICK_W-1:0] T0_TICKS  = TICK_W'(T0H);
  localparam logic [TICK_W-1:0] T1_TICKS  = TICK_W'(T1H);
  localparam logic [TICK_W-1:0] SLOT_END  = TICK_W'(TBIT - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(PIXEL_BITS - 1);

  logic [NUM_REGIONS-1:0][23:0] heldRgb;
  logic [NUM_REGIONS-1:0][23:0] heldGrb;
  logic [23:0]                  shiftReg;
  logic [BIT_W-1:0]             bitIdx;
  logic [TICK_W-1:0]            tick;
  logic                         active;

  // wire order per LED: green, red, blue
  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_reorder
    assign heldGrb[k] = {heldRgb[k][15:8], heldRgb[k][23:16], heldRgb[k][7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldRgb <= '0;
    end else if (strobes.capture) begin
      heldRgb <= modeCustom ? customColors : liveColors;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitIdx    <= '0;
      tick      <= '0;
      active    <= 1'b0;
      pixelDone <= 1'b0;
    end else begin
      pixelDone <= 1'b0;
      if (strobes.startPixel) begin
        shiftReg <= heldGrb[regionSel];
        bitIdx   <= '0;
        tick     <= '0;
        active   <= 1'b1;
      end else if (active) begin
        if (tick == SLOT_END) begin
          tick <= '0;
          if (bitIdx == LAST_BIT) begin
            active    <= 1'b0;
            pixelDone <= 1'b1;
          end else begin
            bitIdx   <= bitIdx + 1'b1;
            shiftReg <= {shiftReg[22:0], 1'b0};
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end

  assign ledData = active && (tick < (shiftReg[23] ? T1_TICKS : T0_TICKS));

endmodule

// File: rtl/ledStreamer.sv
module ledStreamer
  import ledStreamPkg::*;
#(
  parameter int unsigned NUM_REGIONS = 5,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned T0H         = 2,
  parameter int unsigned T1H         = 5,
  parameter int unsigned TBIT        = 8,
  parameter int unsigned LATCH_CYC   = 40,
  localparam int unsigned IDX_W      = $clog2(NUM_REGIONS + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         frameStart,
  input  logic                         modeCustom,
  input  logic [NUM_REGIONS*24-1:0]    liveColors,
  input  logic [NUM_REGIONS*24-1:0]    customColors,
  input  logic [NUM_REGIONS*CNT_W-1:0] regionCounts,
  output logic                         ledData,
  output logic                         busy
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] regionSel;
  logic             pixelDone;

  ledCtrl #(
    .NUM_REGIONS(NUM_REGIONS), .CNT_W(CNT_W), .LATCH_CYC(LATCH_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .regionCounts(regionCounts), .pixelDone(pixelDone),
    .strobes(strobes), .regionSel(regionSel), .busy(busy)
  );

  ledDatapath #(
    .NUM_REGIONS(NUM_REGIONS), .T0H(T0H), .T1H(T1H), .TBIT(TBIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regionSel(regionSel),
    .modeCustom(modeCustom), .liveColors(liveColors),
    .customColors(customColors), .pixelDone(pixelDone), .ledData(ledData)
  );

endmodule

// File: rtl/ledStreamerChk.sv
module ledStreamerChk #(
  parameter int unsigned T0H       = 2,
  parameter int unsigned T1H       = 5,
  parameter int unsigned LATCH_CYC = 40
) (
  input logic clk,
  input logic rstN,
  input logic frameStart,
  input logic ledData,
  input logic busy
);

  logic [15:0] hiRun;
  logic [15:0] loRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiRun <= '0;
      loRun <= '0;
    end else if (ledData) begin
      hiRun <= hiRun + 1'b1;
      loRun <= '0;
    end else begin
      hiRun <= '0;
      if (loRun != 16'hFFFF) loRun <= loRun + 1'b1;
    end
  end

  // R10: quiet line while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ledData);

  // R5: each high pulse is one of the two legal widths
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ledData) |-> (hiRun == 16'(T0H) || hiRun == 16'(T1H)));

  // R8: the latch low time precedes the end of busy
  a_r8_latch_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (loRun >= 16'(LATCH_CYC)));

  // R1: a refresh starts only on a frame-update pulse
  a_r1_start_on_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(frameStart));

endmodule

bind ledStreamer ledStreamerChk #(
  .T0H(T0H), .T1H(T1H), .LATCH_CYC(LATCH_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart),
  .ledData(ledData), .busy(busy)
);

// File: tb/sim_ledStreamer.sv
module sim_ledStreamer;

  localparam int CLK_PERIOD = 10;
  localparam int NR   = 5;
  localparam int T0H  = 2;
  localparam int T1H  = 5;
  localparam int TBIT = 8;
  localparam int LAT  = 40;

  logic clk = 0;
  logic rstN = 0;
  logic frameStart = 0;
  logic modeCustom = 0;
  logic [NR*24-1:0] liveColors = '0;
  logic [NR*24-1:0] customColors = '0;
  logic [NR*8-1:0]  regionCounts = '0;
  logic ledData, busy;

  int checks = 0;
  int errors = 0;
  int hiLen = 0;
  int loLen = 0;
  int widthBad = 0;
  logic bitQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ledStreamer #(.NUM_REGIONS(NR), .T0H(T0H), .T1H(T1H), .TBIT(TBIT), .LATCH_CYC(LAT)) u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .modeCustom(modeCustom),
    .liveColors(liveColors), .customColors(customColors),
    .regionCounts(regionCounts), .ledData(ledData), .busy(busy));

  // pulse-width decoder on the serial line
  always @(negedge clk) begin
    if (!rstN) begin
      hiLen = 0; loLen = 0;
    end else if (ledData) begin
      hiLen++; loLen = 0;
    end else begin
      if (hiLen > 0) begin
        bitQ.push_back(hiLen == T1H);
        if (hiLen != T0H && hiLen != T1H) widthBad++;
      end
      hiLen = 0; loLen++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int countSum(input logic [NR*8-1:0] c);
    int s = 0;
    for (int k = 0; k < NR; k++) s += c[8*k +: 8];
    return s;
  endfunction

  // expected stream built from the requirements: region order, repeats, GRB MSB first
  task automatic buildExpected(input logic [NR*8-1:0] c, input logic [NR*24-1:0] col,
                               ref logic q[$]);
    q.delete();
    for (int k = 0; k < NR; k++) begin
      logic [23:0] rgb = col[24*k +: 24];
      logic [23:0] grb = {rgb[15:8], rgb[23:16], rgb[7:0]};
      for (int n = 0; n < c[8*k +: 8]; n++)
        for (int b = 23; b >= 0; b--) q.push_back(grb[b]);
    end
  endtask

  task automatic runFrame(input string req, input bit disturb);
    logic expQ[$];
    int mism = 0, firstBad = -1;
    buildExpected(regionCounts, modeCustom ? customColors : liveColors, expQ);
    bitQ.delete();
    widthBad = 0;
    frameStart = 1;
    @(negedge clk);
    frameStart = 0;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (disturb) begin
      repeat (60) @(negedge clk);
      liveColors = ~liveColors;
      customColors = customColors ^ {NR{24'h5A5A5A}};
      modeCustom = ~modeCustom;
      regionCounts = regionCounts ^ {NR{8'h03}};
      frameStart = 1;  // R8: ignored while busy
      @(negedge clk);
      frameStart = 0;
    end
    do @(negedge clk); while (busy);
    check(loLen >= LAT, "R8", "low time before busy drop", loLen, LAT);
    check(bitQ.size() == expQ.size(), req, "bit count", bitQ.size(), expQ.size());
    foreach (expQ[i]) if (i < bitQ.size() && bitQ[i] !== expQ[i]) begin
      mism++; if (firstBad < 0) firstBad = i;
    end
    check(mism == 0, req, "stream mismatches (first index in actual)", firstBad, -1);
    check(widthBad == 0, "R5", "illegal pulse widths", widthBad, 0);
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R8", "no second refresh", busy, 0);
    check(ledData == 1'b0, "R10", "line low when idle", ledData, 0);
  endtask

  function automatic logic [NR*24-1:0] rndColors();
    logic [NR*24-1:0] v;
    for (int k = 0; k < NR; k++) v[24*k +: 24] = 24'($urandom);
    return v;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 190000 cycles expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    repeat (3) @(negedge clk);
    check(ledData == 1'b0, "R9", "ledData in reset", ledData, 0);
    check(busy == 1'b0, "R9", "busy in reset", busy, 0);
    rstN = 1;
    @(negedge clk);
    check(busy == 1'b0 && ledData == 1'b0, "R9", "after reset", {busy, ledData}, 0);

    // R2 R4: five regions, nine LEDs, fixed colors for byte order
    liveColors = {24'h102030, 24'hFF0001, 24'h00FF80, 24'hA5C3E7, 24'h123456};
    customColors = rndColors();
    regionCounts = {8'd2, 8'd2, 8'd1, 8'd2, 8'd2};
    modeCustom = 0;
    runFrame("R4", 0);
    check(countSum(regionCounts) == 9, "R2", "nine LEDs", countSum(regionCounts), 9);

    // R6: same counts, custom source
    modeCustom = 1;
    runFrame("R6", 0);

    // R3: zero-count regions in the middle
    modeCustom = 0;
    liveColors = rndColors();
    regionCounts = {8'd2, 8'd0, 8'd1, 8'd0, 8'd3};
    runFrame("R3", 0);

    // R3: all regions zero -> latch only
    regionCounts = '0;
    runFrame("R3", 0);

    // R2: full 8-bit count on one region
    liveColors = rndColors();
    regionCounts = {8'd0, 8'd0, 8'd255, 8'd0, 8'd0};
    runFrame("R2", 0);

    // R7: inputs change mid-refresh, extra start pulse ignored
    liveColors = rndColors();
    customColors = rndColors();
    modeCustom = 1;
    regionCounts = {8'd1, 8'd2, 8'd1, 8'd3, 8'd2};
    runFrame("R7", 1);

    // random frames
    for (int f = 0; f < 8; f++) begin
      liveColors = rndColors();
      customColors = rndColors();
      modeCustom = 1'($urandom);
      for (int k = 0; k < NR; k++) regionCounts[8*k +: 8] = 8'($urandom_range(0, 5));
      runFrame("R2", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule